// File: doc/BRIEF.md
# Debug Mode Exception Controller

This block sits beside the exception logic of a simple in-order CPU and decides when execution enters debug mode, what happens to events raised while debug mode is active, and how debug mode is left. Each cycle the pipeline presents at most one instruction (qualified by `instValid`) together with its PC, a branch flag, and the events attached to it. These events are a normal exception with its cause code, an interrupt, a watchpoint hit, a software breakpoint instruction, an external debug request, and a debug-return.

When a debug entry, a nested debug exception or a debug-return is accepted, the block raises a one-cycle `redirect` together with its target address. It also updates the debug-mode flag, the saved restart PC, and the cause fields. A debug-return can arm a single-step sequence. Exactly one instruction then runs in normal mode, or a branch and its delay slot together. The following instruction traps back into debug mode. A normal exception inside the stepped instruction is allowed to run first, so the trap lands on the first handler instruction.

Top module: `dbg_exc_seq`

## Requirements
- R1: After reset, `dbgMode`, `redirect`, `redirectPc`, `restartPc`, `entryCause` and `nestCause` are all zero.
- R2: In normal mode, a valid instruction with `brkInst` set enters debug mode. One cycle later `redirect` pulses, `dbgMode` is 1, `restartPc` holds that instruction's PC and `entryCause` is 2'b10. A normal exception alone causes no entry.
- R3: In normal mode, `extReq` on a valid instruction enters debug mode with `entryCause` 2'b11. When `brkInst` and `extReq` come together, the breakpoint wins (2'b10).
- R4: The entry target for any debug entry or nested debug exception is `VEC_PROBE` when `probePresent` is 1 and `VEC_ROM` when it is 0, sampled with the event.
- R5: In debug mode, `intReq`, `watchHit` and `extReq` produce no redirect. They leave `dbgMode`, `restartPc` and both cause fields unchanged.
- R6: In debug mode, `excReq` or `brkInst` is a nested debug exception. It redirects to the entry vector, keeps `dbgMode` at 1, loads `restartPc` with the instruction's PC, and leaves `entryCause` alone. `nestCause` takes `excCause`, or `BRK_CODE` (default 9) for a breakpoint alone. `excReq` wins over `brkInst`.
- R7: A valid `dbgRet` in debug mode redirects to `restartPc` and clears `dbgMode`. A nested exception on the same instruction wins instead. Ordinary instructions, branches included, never change `dbgMode`, and `dbgRet` in normal mode is ignored.
- R8: With `stepEn` set at the debug-return, the first valid normal-mode instruction executes. The next valid instruction enters debug mode with `entryCause` 2'b01 and `restartPc` equal to its PC. Idle cycles in between do not count.
- R9: If the stepped instruction has `isBranch` set, it and the following (delay-slot) instruction both execute. The single-step entry occurs on the third instruction.
- R10: If the stepped instruction carries `excReq`, `intReq` or `watchHit`, the single-step entry occurs on the next valid instruction, the first handler instruction, with `restartPc` equal to its PC.
- R11: An armed single-step entry wins over `brkInst` on the same instruction (cause 2'b01). A debug-return with `stepEn` clear arms nothing.
- R12: `redirect` is high only in the single cycle after a valid instruction that caused an entry, a nested exception or a return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| instValid | input | 1 | An instruction is presented this cycle |
| curPc | input | AW | PC of the presented instruction |
| isBranch | input | 1 | Presented instruction is a branch with a delay slot |
| excReq | input | 1 | Presented instruction raises a normal exception |
| excCause | input | CW | Cause code of that exception |
| intReq | input | 1 | Interrupt pending on this instruction |
| watchHit | input | 1 | Watchpoint matched this instruction |
| brkInst | input | 1 | Presented instruction is a software breakpoint |
| extReq | input | 1 | External debug request |
| dbgRet | input | 1 | Presented instruction is a debug-return |
| stepEn | input | 1 | Single-step bit, sampled with the debug-return |
| probePresent | input | 1 | Selects the probe entry vector |
| redirect | output | 1 | One-cycle fetch redirect strobe |
| redirectPc | output | AW | Redirect target |
| dbgMode | output | 1 | Debug-mode flag |
| restartPc | output | AW | Saved restart PC |
| entryCause | output | 2 | Cause of the last entry from normal mode |
| nestCause | output | CW | Cause code of the last nested debug exception |

## Verification
The main sequencing is driven with several step patterns after a stepping debug-return: a plain instruction, a branch with its delay slot, a stepped instruction that faults, and one that takes an interrupt. Each pattern puts the trap on a different instruction, so a miscounted window shows up as a wrong `restartPc`. Debug mode is probed with each filtered event alone and with colliding pairs (exception with breakpoint, exception with return, breakpoint with external request, armed step with breakpoint). These collisions tell the priority order apart from plain filtering. Both vector settings are exercised across entries and nested exceptions.

// File: rtl/dbg_exc_pkg.sv
package dbg_exc_pkg;

  typedef enum logic [1:0] {
    CAUSE_NONE = 2'b00,
    CAUSE_STEP = 2'b01,
    CAUSE_BRK  = 2'b10,
    CAUSE_EXT  = 2'b11
  } entryCause_e;

  typedef enum logic [1:0] {
    STEP_IDLE,
    STEP_RUN,
    STEP_SLOT,
    STEP_ARM
  } stepState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic        enter;
    logic        nest;
    logic        nestBrk;
    logic        ret;
    entryCause_e cause;
  } ctrlStb_t;

endpackage

// File: rtl/dbg_exc_ctrl.sv
module dbg_exc_ctrl
  import dbg_exc_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     instValid,
  input  logic     isBranch,
  input  logic     excReq,
  input  logic     intReq,
  input  logic     watchHit,
  input  logic     brkInst,
  input  logic     extReq,
  input  logic     dbgRet,
  input  logic     stepEn,
  output ctrlStb_t stb,
  output logic     dbgMode
);

  logic       modeQ, modeD;
  stepState_e stepQ, stepD;
  logic       stepTrap;

  // a normal-mode trap of any kind on the stepped instruction
  assign stepTrap = excReq | intReq | watchHit;

  always_comb begin
    stb   = '0;
    modeD = modeQ;
    stepD = stepQ;
    if (instValid) begin
      if (modeQ) begin
        // debug mode: only exceptions and breakpoints nest, return exits
        if (excReq || brkInst) begin
          stb.nest    = 1'b1;
          stb.nestBrk = ~excReq;
        end else if (dbgRet) begin
          stb.ret = 1'b1;
          modeD   = 1'b0;
          stepD   = stepEn ? STEP_RUN : STEP_IDLE;
        end
      end else begin
        if (stepQ == STEP_ARM) begin
          stb.enter = 1'b1;
          stb.cause = CAUSE_STEP;
        end else if (brkInst) begin
          stb.enter = 1'b1;
          stb.cause = CAUSE_BRK;
        end else if (extReq) begin
          stb.enter = 1'b1;
          stb.cause = CAUSE_EXT;
        end
        if (stb.enter) begin
          modeD = 1'b1;
          stepD = STEP_IDLE;
        end else begin
          case (stepQ)
            STEP_RUN:  stepD = stepTrap ? STEP_ARM : (isBranch ? STEP_SLOT : STEP_ARM);
            STEP_SLOT: stepD = STEP_ARM;
            default:   stepD = stepQ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ <= 1'b0;
      stepQ <= STEP_IDLE;
    end else begin
      modeQ <= modeD;
      stepQ <= stepD;
    end
  end

  assign dbgMode = modeQ;

endmodule

// File: rtl/dbg_exc_dpath.sv
module dbg_exc_dpath
  import dbg_exc_pkg::*;
#(
  parameter int             AW        = 32,
  parameter int             CW        = 5,
  parameter logic [AW-1:0]  VEC_PROBE = 32'hFF20_0200,
  parameter logic [AW-1:0]  VEC_ROM   = 32'hBFC0_0480,
  parameter int             BRK_CODE  = 9
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctrlStb_t      stb,
  input  logic [AW-1:0] curPc,
  input  logic [CW-1:0] excCause,
  input  logic          probePresent,
  output logic          redirect,
  output logic [AW-1:0] redirectPc,
  output logic [AW-1:0] restartPc,
  output logic [1:0]    entryCause,
  output logic [CW-1:0] nestCause
);

  localparam logic [CW-1:0] BRK_VAL = CW'(BRK_CODE);

  logic [AW-1:0] vecSel;
  logic          toVector;

  assign vecSel   = probePresent ? VEC_PROBE : VEC_ROM;
  assign toVector = stb.enter | stb.nest;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      redirect   <= 1'b0;
      redirectPc <= '0;
      restartPc  <= '0;
      entryCause <= '0;
      nestCause  <= '0;
    end else begin
      redirect <= toVector | stb.ret;
      if (toVector) begin
        redirectPc <= vecSel;
        restartPc  <= curPc;
      end else if (stb.ret) begin
        redirectPc <= restartPc;
      end
      if (stb.enter) entryCause <= stb.cause;
      if (stb.nest)  nestCause  <= stb.nestBrk ? BRK_VAL : excCause;
    end
  end

endmodule

// File: rtl/dbg_exc_seq.sv
module dbg_exc_seq
  import dbg_exc_pkg::*;
#(
  parameter int             AW        = 32,
  parameter int             CW        = 5,
  parameter logic [AW-1:0]  VEC_PROBE = 32'hFF20_0200,
  parameter logic [AW-1:0]  VEC_ROM   = 32'hBFC0_0480,
  parameter int             BRK_CODE  = 9
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          instValid,
  input  logic [AW-1:0] curPc,
  input  logic          isBranch,
  input  logic          excReq,
  input  logic [CW-1:0] excCause,
  input  logic          intReq,
  input  logic          watchHit,
  input  logic          brkInst,
  input  logic          extReq,
  input  logic          dbgRet,
  input  logic          stepEn,
  input  logic          probePresent,
  output logic          redirect,
  output logic [AW-1:0] redirectPc,
  output logic          dbgMode,
  output logic [AW-1:0] restartPc,
  output logic [1:0]    entryCause,
  output logic [CW-1:0] nestCause
);

  ctrlStb_t stb;

  dbg_exc_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .instValid (instValid),
    .isBranch  (isBranch),
    .excReq    (excReq),
    .intReq    (intReq),
    .watchHit  (watchHit),
    .brkInst   (brkInst),
    .extReq    (extReq),
    .dbgRet    (dbgRet),
    .stepEn    (stepEn),
    .stb       (stb),
    .dbgMode   (dbgMode)
  );

  dbg_exc_dpath #(
    .AW        (AW),
    .CW        (CW),
    .VEC_PROBE (VEC_PROBE),
    .VEC_ROM   (VEC_ROM),
    .BRK_CODE  (BRK_CODE)
  ) u_dpath (
    .clk          (clk),
    .rstN         (rstN),
    .stb          (stb),
    .curPc        (curPc),
    .excCause     (excCause),
    .probePresent (probePresent),
    .redirect     (redirect),
    .redirectPc   (redirectPc),
    .restartPc    (restartPc),
    .entryCause   (entryCause),
    .nestCause    (nestCause)
  );

endmodule

// File: rtl/dbg_exc_seq_chk.sv
module dbg_exc_seq_chk #(
  parameter int            AW        = 32,
  parameter logic [AW-1:0] VEC_PROBE = 32'hFF20_0200,
  parameter logic [AW-1:0] VEC_ROM   = 32'hBFC0_0480
) (
  input logic          clk,
  input logic          rstN,
  input logic          instValid,
  input logic [AW-1:0] curPc,
  input logic          excReq,
  input logic          brkInst,
  input logic          dbgRet,
  input logic          redirect,
  input logic [AW-1:0] redirectPc,
  input logic          dbgMode,
  input logic [AW-1:0] restartPc,
  input logic [1:0]    entryCause
);

  AST_REDIRECT_CAUSED: assert property (@(posedge clk) disable iff (!rstN)
    redirect |-> $past(instValid)); // R12

  AST_DBG_FILTERED: assert property (@(posedge clk) disable iff (!rstN)
    (dbgMode && instValid && !excReq && !brkInst && !dbgRet) |=> (!redirect && dbgMode)); // R5

  AST_NEST_STAYS: assert property (@(posedge clk) disable iff (!rstN)
    (dbgMode && instValid && excReq) |=> (redirect && dbgMode && restartPc == $past(curPc))); // R6

  AST_RET_EXITS: assert property (@(posedge clk) disable iff (!rstN)
    (dbgMode && instValid && dbgRet && !excReq && !brkInst)
      |=> (redirect && !dbgMode && redirectPc == $past(restartPc))); // R7

  AST_BRK_ENTERS: assert property (@(posedge clk) disable iff (!rstN)
    (!dbgMode && instValid && brkInst) |=> (redirect && dbgMode)); // R2

  AST_VECTOR_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    (redirect && dbgMode) |-> (redirectPc == VEC_PROBE || redirectPc == VEC_ROM)); // R4

  AST_ENTRY_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dbgMode) |-> (entryCause != 2'b00)); // R2

endmodule

bind dbg_exc_seq dbg_exc_seq_chk #(
  .AW        (AW),
  .VEC_PROBE (VEC_PROBE),
  .VEC_ROM   (VEC_ROM)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .instValid  (instValid),
  .curPc      (curPc),
  .excReq     (excReq),
  .brkInst    (brkInst),
  .dbgRet     (dbgRet),
  .redirect   (redirect),
  .redirectPc (redirectPc),
  .dbgMode    (dbgMode),
  .restartPc  (restartPc),
  .entryCause (entryCause)
);

// File: tb/dbg_exc_seq_tb.sv
`timescale 1ns/1ps
module dbg_exc_seq_tb;

  localparam logic [31:0] VP = 32'hFF20_0200;
  localparam logic [31:0] VR = 32'hBFC0_0480;

  localparam logic [7:0] F_V  = 8'h01;
  localparam logic [7:0] F_BR = 8'h02;
  localparam logic [7:0] F_EX = 8'h04;
  localparam logic [7:0] F_IN = 8'h08;
  localparam logic [7:0] F_WA = 8'h10;
  localparam logic [7:0] F_BP = 8'h20;
  localparam logic [7:0] F_DR = 8'h40;
  localparam logic [7:0] F_RT = 8'h80;

  logic        clk = 1'b0;
  logic        rstN;
  logic        instValid, isBranch, excReq, intReq, watchHit, brkInst, extReq, dbgRet;
  logic        stepEn, probePresent;
  logic [31:0] curPc;
  logic [4:0]  excCause;
  logic        redirect, dbgMode;
  logic [31:0] redirectPc, restartPc;
  logic [1:0]  entryCause;
  logic [4:0]  nestCause;

  always #2.5 clk = ~clk;

  dbg_exc_seq u_dut (
    .clk(clk), .rstN(rstN), .instValid(instValid), .curPc(curPc), .isBranch(isBranch),
    .excReq(excReq), .excCause(excCause), .intReq(intReq), .watchHit(watchHit),
    .brkInst(brkInst), .extReq(extReq), .dbgRet(dbgRet), .stepEn(stepEn),
    .probePresent(probePresent), .redirect(redirect), .redirectPc(redirectPc),
    .dbgMode(dbgMode), .restartPc(restartPc), .entryCause(entryCause), .nestCause(nestCause)
  );

  typedef struct {
    logic        redir;
    logic [31:0] tgt;
    logic        dbg;
    logic [31:0] depc;
    logic [1:0]  ec;
    logic [4:0]  nc;
    string       tag;
  } item_t;

  item_t expq[$];
  int    nChecks = 0;
  int    nFails  = 0;
  bit    done    = 0;

  // staged expectations and mode inputs, applied by the driver
  logic        eDbg = 0;
  logic [31:0] eDepc = 0;
  logic [1:0]  eEc = 0;
  logic [4:0]  eNc = 0;
  logic        pStep = 0;
  logic        pProbe = 1;

  task automatic ins(input logic [31:0] pc, input logic [7:0] fl, input logic [4:0] code,
                     input logic er, input logic [31:0] et, input string tag);
    item_t it;
    @(negedge clk);
    curPc = pc; excCause = code;
    instValid = fl[0]; isBranch = fl[1]; excReq = fl[2]; intReq = fl[3];
    watchHit = fl[4]; brkInst = fl[5]; extReq = fl[6]; dbgRet = fl[7];
    stepEn = pStep; probePresent = pProbe;
    it.redir = er; it.tgt = et; it.dbg = eDbg; it.depc = eDepc;
    it.ec = eEc; it.nc = eNc; it.tag = tag;
    expq.push_back(it);
  endtask

  // monitor: compare one expected item per clock, just after the edge
  item_t got;
  always @(posedge clk) begin
    #1;
    if (expq.size() > 0) begin
      got = expq.pop_front();
      nChecks++;
      if (redirect !== got.redir || (got.redir && redirectPc !== got.tgt) ||
          dbgMode !== got.dbg || restartPc !== got.depc ||
          entryCause !== got.ec || nestCause !== got.nc) begin
        nFails++;
        $display("FAIL %s act redir=%0b tgt=%h dbg=%0b depc=%h ec=%0d nc=%0d exp redir=%0b tgt=%h dbg=%0b depc=%h ec=%0d nc=%0d",
                 got.tag, redirect, redirectPc, dbgMode, restartPc, entryCause, nestCause,
                 got.redir, got.tgt, got.dbg, got.depc, got.ec, got.nc);
      end
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      nFails++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    rstN = 0; curPc = 0; excCause = 0;
    instValid = 0; isBranch = 0; excReq = 0; intReq = 0; watchHit = 0;
    brkInst = 0; extReq = 0; dbgRet = 0; stepEn = 0; probePresent = 1;
    repeat (3) @(posedge clk);
    #1;
    nChecks++;
    if (redirect !== 0 || dbgMode !== 0 || restartPc !== 0 || redirectPc !== 0 ||
        entryCause !== 0 || nestCause !== 0) begin
      nFails++;
      $display("FAIL R1 reset act redir=%0b dbg=%0b depc=%h ec=%0d nc=%0d exp all zero",
               redirect, dbgMode, restartPc, entryCause, nestCause);
    end
    @(negedge clk) rstN = 1;

    ins(32'h0, 8'h00, 0, 0, 0, "R1 idle after reset");
    ins(32'h100, F_V|F_EX, 5'd4, 0, 0, "R2 plain exception no entry");
    eDbg = 1; eDepc = 32'h104; eEc = 2'b10;
    ins(32'h104, F_V|F_BP|F_DR, 0, 1, VP, "R3 breakpoint beats external");
    ins(32'h0, 8'h00, 0, 0, 0, "R12 redirect single cycle");
    ins(32'h200, F_V|F_IN|F_WA|F_DR, 0, 0, 0, "R5 filtered in debug");
    ins(32'h204, F_V|F_BR, 0, 0, 0, "R7 branch keeps debug mode");
    eDepc = 32'h208; eNc = 5'd4;
    ins(32'h208, F_V|F_EX, 5'd4, 1, VP, "R6 nested exception");
    eDepc = 32'h20C; eNc = 5'd9;
    ins(32'h20C, F_V|F_BP, 0, 1, VP, "R6 nested breakpoint code");
    eDepc = 32'h210; eNc = 5'd7;
    ins(32'h210, F_V|F_EX|F_BP, 5'd7, 1, VP, "R6 exception beats breakpoint");
    eDepc = 32'h214; eNc = 5'd3;
    ins(32'h214, F_V|F_EX|F_RT, 5'd3, 1, VP, "R7 nested beats return");
    eDbg = 0;
    ins(32'h218, F_V|F_RT, 0, 1, 32'h214, "R7 return exits");
    ins(32'h214, F_V, 0, 0, 0, "R11 no step armed");
    ins(32'h218, F_V, 0, 0, 0, "R11 no step armed");
    ins(32'h21C, F_V|F_RT, 0, 0, 0, "R7 return ignored in normal mode");

    pProbe = 0; eDbg = 1; eDepc = 32'h300; eEc = 2'b11;
    ins(32'h300, F_V|F_DR, 0, 1, VR, "R4 rom vector external entry");
    pStep = 1; eDbg = 0;
    ins(32'h900, F_V|F_RT, 0, 1, 32'h300, "R8 stepping return");
    ins(32'h300, F_V, 0, 0, 0, "R8 stepped instruction runs");
    ins(32'h0, 8'h00, 0, 0, 0, "R8 idle does not count");
    eDbg = 1; eDepc = 32'h304; eEc = 2'b01;
    ins(32'h304, F_V, 0, 1, VR, "R8 single-step entry");

    eDbg = 0;
    ins(32'h904, F_V|F_RT, 0, 1, 32'h304, "R9 stepping return");
    ins(32'h304, F_V|F_BR, 0, 0, 0, "R9 branch runs");
    ins(32'h308, F_V, 0, 0, 0, "R9 delay slot runs");
    eDbg = 1; eDepc = 32'h30C;
    ins(32'h30C, F_V, 0, 1, VR, "R9 step entry after slot");

    eDbg = 0;
    ins(32'h908, F_V|F_RT, 0, 1, 32'h30C, "R10 stepping return");
    ins(32'h30C, F_V|F_EX, 5'd12, 0, 0, "R10 stepped instruction faults");
    eDbg = 1; eDepc = 32'h180;
    ins(32'h180, F_V, 0, 1, VR, "R10 step entry at handler");

    pProbe = 1; eDbg = 0;
    ins(32'h90C, F_V|F_RT, 0, 1, 32'h180, "R10 stepping return");
    ins(32'h180, F_V|F_IN, 0, 0, 0, "R10 stepped instruction interrupted");
    eDbg = 1; eDepc = 32'h400;
    ins(32'h400, F_V|F_BP, 0, 1, VP, "R11 step beats breakpoint");

    pStep = 0; eDbg = 0;
    ins(32'h910, F_V|F_RT, 0, 1, 32'h400, "R11 plain return");
    ins(32'h400, F_V, 0, 0, 0, "R11 no trap after plain return");
    ins(32'h404, F_V, 0, 0, 0, "R11 no trap after plain return");
    eDbg = 1; eDepc = 32'h408; eEc = 2'b10;
    ins(32'h408, F_V|F_BP, 0, 1, VP, "R2 breakpoint entry");
    ins(32'h0, 8'h00, 0, 0, 0, "R12 redirect drops");

    repeat (3) @(negedge clk);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
    $finish;
  end

endmodule